// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiply-Accumulate Array

This block computes one tile of D = A*B + C on signed integers. It uses a grid of M by N processing elements. One start pulse hands the block an M x K tile A, a K x N tile B and an M x N accumulator tile C. On that edge the block captures all three tiles and loads each element's sum register with its C value. From the next cycle on, skew logic at the edges feeds the array. Row i of A enters the left column i cycles late and moves one element to the right per cycle. Column j of B enters the top row j cycles late and moves one element down per cycle. The operands that belong together therefore arrive at element (i,j) in the same cycle. Each element multiplies the pair, sign-extends the product and adds it to its own sum, which stays in place.

After K+M+N-2 cycles of operand flow, every sum is final. A one-cycle valid strobe then marks the whole result tile, which is presented on a parallel bus. The result stays there until the next start is accepted. A start that arrives while a tile is still flowing is dropped. The default build is a 4x4x4 tile with 8-bit operands and 32-bit sums.

Top module: `sysmma_array`

## Requirements
- R1: When valid is high, element (i,j) of d_tile equals C[i][j] + sum over k of A[i][k]*B[k][j]. The operands are two's-complement signed values of DW bits.
- R2: On the cycle after an accepted start, d_tile equals the c_tile that was sampled with start. This is the preload of every sum.
- R3: Each product is sign-extended to AW bits before it is added. The sum wraps modulo 2^AW and never saturates.
- R4: valid is high for exactly one cycle. It rises on the (K+M+N-2)-th rising edge after the edge that accepted start, and never outside that cycle.
- R5: busy is high from the edge that accepts start until the edge that raises valid. On that edge busy falls.
- R6: start is accepted only while busy is low. A start seen while busy is high leaves the running tile, its result and its timing unchanged.
- R7: d_tile does not change while busy is low, unless a start is accepted.
- R8: Tile packing. A[i][k] lies at bits (i*K+k)*DW of a_tile, and B[k][j] lies at bits (k*N+j)*DW of b_tile. C[i][j] and D[i][j] lie at bits (i*N+j)*AW of c_tile and d_tile, each field being AW bits wide.
- R9: After reset, busy, valid and d_tile are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile; sampled with the three tiles |
| a_tile | input | M*K*DW | Left operand tile, packed per R8 |
| b_tile | input | K*N*DW | Top operand tile, packed per R8 |
| c_tile | input | M*N*AW | Accumulator preload tile, packed per R8 |
| busy | output | 1 | Tile in flight |
| valid | output | 1 | One-cycle strobe: d_tile holds the result |
| d_tile | output | M*N*AW | Result tile, packed per R8 |

## Verification
The bench builds the block with its default values: M=N=K=4, DW=8 and AW=32. With these values the full 16-element result can be compared exactly against a reference model written in the bench, and the skew and latency are those of the native 4x4x4 tile, with valid after 10 cycles. The 8-bit operand range lets the test reach the extremes directly: all -128 operands, and a C of 0x7FFFFFFF that forces the 32-bit sum to wrap. The short tile also leaves time to fire extra start pulses in the middle of the operand flow.

// File: rtl/sysmma_pkg.sv
package sysmma_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mma_state_e;

   function automatic int flow_steps(input int m, input int n, input int k);
      return k + m + n - 2;
   endfunction
endpackage

// File: rtl/sysmma_ctrl.sv
module sysmma_ctrl #(
   parameter int STEPS = 10,
   localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          load,
   output logic          run,
   output logic [SW-1:0] step,
   output logic          done
);
   import sysmma_pkg::*;

   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   mma_state_e state;

   assign run  = (state == ST_RUN);
   assign load = start && (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         step  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_RUN;
                  step  <= '0;
               end
            end
            ST_RUN: begin
               if (step == LAST) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  step <= step + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sysmma_skew.sv
module sysmma_skew #(
   parameter int LANES = 4,
   parameter int K     = 4,
   parameter int DW    = 8,
   parameter bit ROWWISE = 1'b1,
   parameter int SW    = 4
) (
   input  logic                  run,
   input  logic [SW-1:0]         step,
   input  logic [LANES*K*DW-1:0] tile,
   output logic [LANES*DW-1:0]   edge_q
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DW-1:0] val;
      always_comb begin
         val = '0;
         for (int k = 0; k < K; k++) begin
            if (run && (int'(step) == l + k)) begin
               if (ROWWISE) val = tile[(l*K + k)*DW +: DW];
               else         val = tile[(k*LANES + l)*DW +: DW];
            end
         end
      end
      assign edge_q[l*DW +: DW] = val;
   end
endmodule

// File: rtl/sysmma_pe.sv
module sysmma_pe #(
   parameter int DW = 8,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] preload,
   input  logic          en,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   output logic [DW-1:0] a_out,
   output logic [DW-1:0] b_out,
   output logic [AW-1:0] acc
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] prod;
   logic        [AW-1:0] prod_ext;

   assign prod = $signed(a_in) * $signed(b_in);

   if (AW > PW) begin : g_ext
      assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
   end else begin : g_fit
      assign prod_ext = prod[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         a_out <= '0;
         b_out <= '0;
      end else if (load) begin
         acc   <= preload;
         a_out <= '0;
         b_out <= '0;
      end else if (en) begin
         acc   <= acc + prod_ext;
         a_out <= a_in;
         b_out <= b_in;
      end
   end
endmodule

// File: rtl/sysmma_array.sv
module sysmma_array #(
   parameter int M  = 4,
   parameter int N  = 4,
   parameter int K  = 4,
   parameter int DW = 8,
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [M*K*DW-1:0] a_tile,
   input  logic [K*N*DW-1:0] b_tile,
   input  logic [M*N*AW-1:0] c_tile,
   output logic              busy,
   output logic              valid,
   output logic [M*N*AW-1:0] d_tile
);
   localparam int STEPS = sysmma_pkg::flow_steps(M, N, K);
   localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

   if (M < 1 || N < 1 || K < 1) begin : g_bad_dim
      $error("sysmma_array: tile dimensions must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("sysmma_array: operand width must be at least 2");
   end
   if (AW < 2 * DW) begin : g_bad_aw
      $error("sysmma_array: sum width must hold a full product");
   end

   logic              load, run;
   logic [SW-1:0]     step;
   logic [M*K*DW-1:0] a_q;
   logic [K*N*DW-1:0] b_q;
   logic [M*DW-1:0]   a_edge;
   logic [N*DW-1:0]   b_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= a_tile;
         b_q <= b_tile;
      end
   end

   sysmma_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .run(run), .step(step), .done(valid)
   );

   sysmma_skew #(.LANES(M), .K(K), .DW(DW), .ROWWISE(1'b1), .SW(SW)) u_skew_a (
      .run(run), .step(step), .tile(a_q), .edge_q(a_edge)
   );

   sysmma_skew #(.LANES(N), .K(K), .DW(DW), .ROWWISE(1'b0), .SW(SW)) u_skew_b (
      .run(run), .step(step), .tile(b_q), .edge_q(b_edge)
   );

   logic [DW-1:0] a_link [M][N];
   logic [DW-1:0] b_link [M][N];

   for (genvar i = 0; i < M; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         logic [DW-1:0] a_src, b_src;
         if (j == 0) begin : g_a_edge
            assign a_src = a_edge[i*DW +: DW];
         end else begin : g_a_link
            assign a_src = a_link[i][j-1];
         end
         if (i == 0) begin : g_b_edge
            assign b_src = b_edge[j*DW +: DW];
         end else begin : g_b_link
            assign b_src = b_link[i-1][j];
         end
         sysmma_pe #(.DW(DW), .AW(AW)) u_pe (
            .clk(clk), .rst_n(rst_n),
            .load(load), .preload(c_tile[(i*N + j)*AW +: AW]),
            .en(run), .a_in(a_src), .b_in(b_src),
            .a_out(a_link[i][j]), .b_out(b_link[i][j]),
            .acc(d_tile[(i*N + j)*AW +: AW])
         );
      end
   end

   assign busy = run;
endmodule

// File: rtl/sysmma_chk.sv
module sysmma_chk #(
   parameter int M  = 4,
   parameter int N  = 4,
   parameter int K  = 4,
   parameter int AW = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              valid,
   input logic [M*N*AW-1:0] c_tile,
   input logic [M*N*AW-1:0] d_tile
);
   localparam int STEPS = K + M + N - 2;

   logic [15:0] flow_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flow_cnt <= '0;
      else if (start && !busy) flow_cnt <= '0;
      else if (busy)           flow_cnt <= flow_cnt + 1'b1;
   end

   // R2
   p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> d_tile == $past(c_tile));

   // R4
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> flow_cnt == 16'(STEPS));

   p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R5
   p_busy_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> valid);

   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && valid));

   // R6
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && flow_cnt < 16'(STEPS - 1) |=> busy && flow_cnt == $past(flow_cnt) + 16'd1);

   // R7
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(d_tile));
endmodule

bind sysmma_array sysmma_chk #(.M(M), .N(N), .K(K), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .valid(valid), .c_tile(c_tile), .d_tile(d_tile)
);

// File: tb/sim_sysmma_array.sv
module sim_sysmma_array;
   localparam int CLK_PERIOD = 10;
   localparam int M = 4, N = 4, K = 4, DW = 8, AW = 32;
   localparam int STEPS = K + M + N - 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [M*K*DW-1:0] a_tile = '0;
   logic [K*N*DW-1:0] b_tile = '0;
   logic [M*N*AW-1:0] c_tile = '0;
   logic              busy, valid;
   logic [M*N*AW-1:0] d_tile;

   sysmma_array #(.M(M), .N(N), .K(K), .DW(DW), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .a_tile(a_tile),
      .b_tile(b_tile), .c_tile(c_tile), .busy(busy), .valid(valid), .d_tile(d_tile)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { logic [M*N*AW-1:0] d; int t0; } exp_t;
   exp_t sb_q [$];
   logic [M*N*AW-1:0] last_exp;

   logic signed [DW-1:0] am [M][K];
   logic signed [DW-1:0] bm [K][N];
   logic        [AW-1:0] cm [M][N];

   task automatic check(input string tag, input logic [M*N*AW-1:0] act,
                        input logic [M*N*AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected tiles when valid strobes (R1, R3, R4)
   always @(negedge clk) begin
      if (rst_n && valid) begin
         if (sb_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R4 unexpected valid act=1 exp=0");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check("R1 result tile", d_tile, e.d);
            check("R4 latency", 512'(cyc - e.t0), 512'(STEPS + 1));
         end
      end
   end

   task automatic pack_and_expect(output logic [M*N*AW-1:0] exp);
      for (int i = 0; i < M; i++)
         for (int k = 0; k < K; k++) a_tile[(i*K+k)*DW +: DW] = am[i][k];
      for (int k = 0; k < K; k++)
         for (int j = 0; j < N; j++) b_tile[(k*N+j)*DW +: DW] = bm[k][j];
      for (int i = 0; i < M; i++)
         for (int j = 0; j < N; j++) begin
            bit [31:0] s;
            s = cm[i][j];
            for (int k = 0; k < K; k++) begin
               int p;
               p = int'(am[i][k]) * int'(bm[k][j]);
               s = s + 32'(p);
            end
            c_tile[(i*N+j)*AW +: AW] = cm[i][j];
            exp[(i*N+j)*AW +: AW] = s;
         end
   endtask

   task automatic run_tile(input bit poke);
      logic [M*N*AW-1:0] exp, c_sent;
      exp_t e;
      @(negedge clk);
      pack_and_expect(exp);
      c_sent = c_tile;
      start = 1'b1;
      e.d = exp; e.t0 = cyc;
      sb_q.push_back(e);
      last_exp = exp;
      @(negedge clk);
      start = 1'b0;
      check("R2 preload", d_tile, c_sent);
      check("R5 busy high", 512'(busy), 512'(1));
      if (poke) begin
         // R6: new tiles and start pulses during flight must be dropped
         a_tile = ~a_tile; b_tile = ~b_tile; c_tile = ~c_tile;
         repeat (2) @(negedge clk);
         start = 1'b1;
         repeat (3) @(negedge clk);
         start = 1'b0;
         check("R6 still busy", 512'(busy), 512'(1));
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      check("R4 pulse low", 512'(valid), 512'(0));
   endtask

   task automatic fill(input int mode);
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++) begin
            case (mode)
               0: begin am[i][j] = 0; bm[i][j] = DW'($urandom); cm[i][j] = $urandom; end
               1: begin am[i][j] = (i == j) ? 8'sd1 : 8'sd0; bm[i][j] = DW'($urandom); cm[i][j] = 0; end
               2: begin am[i][j] = DW'($urandom); bm[i][j] = DW'($urandom); cm[i][j] = $urandom; end
               3: begin am[i][j] = -8'sd128; bm[i][j] = -8'sd128; cm[i][j] = 0; end
               4: begin am[i][j] = -8'sd128; bm[i][j] = 8'sd127; cm[i][j] = 32'hFFFF_FFFF; end
               default: begin am[i][j] = 8'sd127; bm[i][j] = 8'sd127; cm[i][j] = 32'h7FFF_FFFF; end
            endcase
         end
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      check("R9 reset d", d_tile, '0);
      check("R9 reset busy", 512'(busy), 512'(0));
      check("R9 reset valid", 512'(valid), 512'(0));
      rst_n = 1'b1;
      @(negedge clk);
      fill(0); run_tile(1'b0);   // R1 zero A: D == C
      fill(1); run_tile(1'b0);   // R1 R8 identity A: D == B
      fill(2); run_tile(1'b0);
      fill(2); run_tile(1'b0);
      fill(3); run_tile(1'b0);   // R3 sign extension of large products
      fill(4); run_tile(1'b0);   // R3 negative products
      fill(5); run_tile(1'b0);   // R3 wrap past 2^31
      fill(2); run_tile(1'b1);   // R6 start during flight ignored
      a_tile = ~a_tile; c_tile = ~c_tile;
      repeat (5) @(negedge clk);
      check("R7 hold", d_tile, last_exp);
      check("R5 idle", 512'(busy), 512'(0));
      check("R1 queue drained", 512'(sb_q.size()), 512'(0));
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule